// File: doc/BRIEF.md
# Transmit Descriptor Request Gate

This block decides when a frame-oriented transmit engine may raise data requests towards a bus-mastering DMA interface. It walks an indexed transmit descriptor store, one frame per descriptor. For each descriptor it presents the index, captures the descriptor's wrap and end-of-chain flags, and then opens the request gate until the data path reports that the frame has finished. Software starts the walk by writing a start index and then raising an enable bit.

Dropping the enable bit never cuts a frame short. The engine finishes the frame in flight, stops at the boundary and leaves the index of the descriptor it would have fetched next in a readable resume register. A frame that completes with an error parks the engine in an error hold. The engine leaves that hold only when software flips a clear-toggle bit. While the engine is in this hold, a drop of the enable bit is not acted on until the toggle arrives.

Top module: `tx_dma_gate`

## Requirements
- R1: `dma_req_en` is high only in the transfer phase. The transfer phase begins on the second clock edge after a fetch starts: one edge loads the index, the next captures the descriptor flags.
- R2: Once `dma_req_en` is high, it stays high until a `frame_done` pulse has been sampled, whatever `tx_en` does. Without an error it then falls for one boundary cycle.
- R3: When the engine stops at a frame boundary, or enters the error hold, `resume_ptr` is loaded with the index of the next descriptor.
- R4: In the error hold, a change of `err_clr_tgl` with `tx_en` at 1 restarts fetching at `resume_ptr`. With `tx_en` at 0, the same change moves the engine to the stopped state. Without such a change the engine stays in the hold, whatever `tx_en` does.
- R5: A 0-to-1 transition of `tx_en` while the engine is idle or stopped starts a fetch at `start_ptr`. `desc_idx` shows that value on the next clock.
- R6: The index of the next descriptor is 0 when the current descriptor's wrap flag (`desc_wrap`, sampled in the fetch cycle) was 1. Otherwise it is the current index plus one, modulo 2^IDX_W (255 is followed by 0).
- R7: `stalled` is high in the stopped state and in the error hold, and low otherwise. It is never high together with `dma_req_en`.
- R8: A change of `err_clr_tgl` in either direction counts as a clear. A change outside the error hold has no effect.
- R9: At a frame boundary the engine fetches the next descriptor only when `tx_en` is 1 and the finished descriptor's end-of-chain flag (`desc_last`) was 0. Otherwise it stops.
- R10: After reset, `dma_req_en`, `stalled`, `desc_idx` and `resume_ptr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Software transmit enable |
| err_clr_tgl | input | 1 | Software clear toggle; each change releases the error hold |
| start_ptr | input | IDX_W | Start descriptor index programmed by software |
| desc_wrap | input | 1 | Wrap flag of the descriptor at `desc_idx` |
| desc_last | input | 1 | End-of-chain flag of the descriptor at `desc_idx` |
| frame_done | input | 1 | One-cycle pulse from the data path at the end of a frame |
| frame_err | input | 1 | Qualifies `frame_done`: the frame ended with an error |
| dma_req_en | output | 1 | Permission for the engine to issue data requests |
| desc_idx | output | IDX_W | Index of the current descriptor |
| resume_ptr | output | IDX_W | Index saved when the engine stops |
| stalled | output | 1 | Engine is stopped or held on an error |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a drop of `tx_en` and the end of a frame. The bench clears the enable a few cycles into a frame and again in the very cycle of the `frame_done` pulse, and expects the engine to stop at that boundary in both cases. The second pair is a clear toggle and a disable during the error hold. The bench flips the toggle while `tx_en` is already low, and expects the engine to stop rather than resume. A behavioural reference model, which looks up the wrap and end-of-chain flags from its own index, judges every output on every cycle.

// File: rtl/tx_dma_gate_pkg.sv
package tx_dma_gate_pkg;
  localparam int unsigned IDX_W_DEF = 8;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_FETCH     = 3'd1,
    ST_XFER      = 3'd2,
    ST_FRAME_END = 3'd3,
    ST_ERR_HOLD  = 3'd4,
    ST_STOPPED   = 3'd5
  } gate_state_e;

  // successor index: wrap to zero or step with natural modulo
  function automatic logic [IDX_W_DEF-1:0] succ_idx(input logic [IDX_W_DEF-1:0] cur,
                                                    input logic wrap);
    return wrap ? '0 : cur + 1'b1;
  endfunction
endpackage

// File: rtl/tx_edge_det.sv
module tx_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic rise,
  output logic change
);
  logic sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig;
  end

  assign rise   = sig & ~sig_q;
  assign change = sig ^ sig_q;
endmodule

// File: rtl/tx_desc_ptr.sv
module tx_desc_ptr #(
  parameter int unsigned IDX_W = tx_dma_gate_pkg::IDX_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] start_ptr,
  input  logic             desc_wrap,
  input  logic             desc_last,
  input  logic             ld_start,
  input  logic             ld_resume,
  input  logic             latch_desc,
  input  logic             step,
  input  logic             save,
  output logic [IDX_W-1:0] cur_idx,
  output logic [IDX_W-1:0] resume_idx,
  output logic             last_q
);
  logic             wrap_q;
  logic [IDX_W-1:0] nxt_idx;

  assign nxt_idx = wrap_q ? '0 : cur_idx + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_idx    <= '0;
      resume_idx <= '0;
      wrap_q     <= 1'b0;
      last_q     <= 1'b0;
    end else begin
      if (latch_desc) begin
        wrap_q <= desc_wrap;
        last_q <= desc_last;
      end
      if (ld_start)       cur_idx <= start_ptr;
      else if (ld_resume) cur_idx <= resume_idx;
      else if (step)      cur_idx <= nxt_idx;
      if (save) resume_idx <= nxt_idx;
    end
  end

  // R5
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_start |=> cur_idx == $past(start_ptr));

  // R6
  step_succ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> cur_idx == ($past(wrap_q) ? '0 : $past(cur_idx) + 1'b1));

  // R3
  save_succ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    save |=> resume_idx == ($past(wrap_q) ? '0 : $past(cur_idx) + 1'b1));
endmodule

// File: rtl/tx_gate_fsm.sv
module tx_gate_fsm
  import tx_dma_gate_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_en,
  input  logic        en_rise,
  input  logic        tgl_chg,
  input  logic        frame_done,
  input  logic        frame_err,
  input  logic        last_q,
  output gate_state_e state,
  output logic        ld_start,
  output logic        ld_resume,
  output logic        latch_desc,
  output logic        step,
  output logic        save
);
  gate_state_e nxt;

  always_comb begin
    nxt        = state;
    ld_start   = 1'b0;
    ld_resume  = 1'b0;
    latch_desc = 1'b0;
    step       = 1'b0;
    save       = 1'b0;
    unique case (state)
      ST_IDLE, ST_STOPPED: begin
        if (en_rise) begin
          nxt      = ST_FETCH;
          ld_start = 1'b1;
        end
      end
      ST_FETCH: begin
        latch_desc = 1'b1;
        nxt        = ST_XFER;
      end
      ST_XFER: begin
        if (frame_done) begin
          if (frame_err) begin
            nxt  = ST_ERR_HOLD;
            save = 1'b1;
          end else begin
            nxt = ST_FRAME_END;
          end
        end
      end
      ST_FRAME_END: begin
        if (tx_en && !last_q) begin
          nxt  = ST_FETCH;
          step = 1'b1;
        end else begin
          nxt  = ST_STOPPED;
          save = 1'b1;
        end
      end
      ST_ERR_HOLD: begin
        if (tgl_chg) begin
          if (tx_en) begin
            nxt       = ST_FETCH;
            ld_resume = 1'b1;
          end else begin
            nxt = ST_STOPPED;
          end
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  // R2
  xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_XFER && !frame_done) |=> state == ST_XFER);

  // R4
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ERR_HOLD && !tgl_chg) |=> state == ST_ERR_HOLD);

  // R9
  chain_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FRAME_END && last_q) |=> state == ST_STOPPED);

  // R1
  fetch_to_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_FETCH |=> state == ST_XFER);
endmodule

// File: rtl/tx_dma_gate.sv
module tx_dma_gate
  import tx_dma_gate_pkg::*;
#(
  parameter int unsigned IDX_W = IDX_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             err_clr_tgl,
  input  logic [IDX_W-1:0] start_ptr,
  input  logic             desc_wrap,
  input  logic             desc_last,
  input  logic             frame_done,
  input  logic             frame_err,
  output logic             dma_req_en,
  output logic [IDX_W-1:0] desc_idx,
  output logic [IDX_W-1:0] resume_ptr,
  output logic             stalled
);
  gate_state_e state;
  logic en_rise, en_chg_unused;
  logic tgl_rise_unused, tgl_chg;
  logic ld_start, ld_resume, latch_desc, step, save, last_q;

  tx_edge_det u_en_det (
    .clk(clk), .rst_n(rst_n), .sig(tx_en), .rise(en_rise), .change(en_chg_unused)
  );

  tx_edge_det u_tgl_det (
    .clk(clk), .rst_n(rst_n), .sig(err_clr_tgl), .rise(tgl_rise_unused), .change(tgl_chg)
  );

  tx_gate_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .en_rise(en_rise), .tgl_chg(tgl_chg),
    .frame_done(frame_done), .frame_err(frame_err), .last_q(last_q), .state(state),
    .ld_start(ld_start), .ld_resume(ld_resume), .latch_desc(latch_desc),
    .step(step), .save(save)
  );

  tx_desc_ptr #(.IDX_W(IDX_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .start_ptr(start_ptr), .desc_wrap(desc_wrap),
    .desc_last(desc_last), .ld_start(ld_start), .ld_resume(ld_resume),
    .latch_desc(latch_desc), .step(step), .save(save), .cur_idx(desc_idx),
    .resume_idx(resume_ptr), .last_q(last_q)
  );

  assign dma_req_en = (state == ST_XFER);
  assign stalled    = (state == ST_STOPPED) || (state == ST_ERR_HOLD);

  // R7
  stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(stalled && dma_req_en));

  // R8
  tgl_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgl_chg && state != ST_ERR_HOLD && !en_rise) |=> $stable(desc_idx));

  // R2
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dma_req_en) |-> $past(frame_done));
endmodule

// File: tb/test_tx_dma_gate.sv
module test_tx_dma_gate;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0;
  logic       err_clr_tgl = 1'b0;
  logic [7:0] start_ptr = 8'h00;
  logic       desc_wrap, desc_last;
  logic       frame_done = 1'b0;
  logic       frame_err = 1'b0;
  logic       dma_req_en, stalled;
  logic [7:0] desc_idx, resume_ptr;

  int wrap_at = 999;
  int last_at = 999;
  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  assign desc_wrap = (int'(desc_idx) == wrap_at);
  assign desc_last = (int'(desc_idx) == last_at);

  tx_dma_gate i_tx_dma_gate (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .err_clr_tgl(err_clr_tgl),
    .start_ptr(start_ptr), .desc_wrap(desc_wrap), .desc_last(desc_last),
    .frame_done(frame_done), .frame_err(frame_err), .dma_req_en(dma_req_en),
    .desc_idx(desc_idx), .resume_ptr(resume_ptr), .stalled(stalled)
  );

  // behavioural reference: phase 0 idle, 1 fetch, 2 sending, 3 boundary, 4 error hold, 5 stopped
  int m_ph, m_idx, m_sav, m_en_prev, m_tg_prev;
  bit m_wrap, m_last;

  function automatic int after(int i, bit w);
    if (w) return 0;
    return (i + 1) % 256;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_idx = 0; m_sav = 0; m_en_prev = 0; m_tg_prev = 0;
      m_wrap = 0; m_last = 0;
    end else begin
      if (m_ph == 0 || m_ph == 5) begin
        if (tx_en && m_en_prev == 0) begin m_idx = int'(start_ptr); m_ph = 1; end
      end else if (m_ph == 1) begin
        m_wrap = (m_idx == wrap_at); m_last = (m_idx == last_at); m_ph = 2;
      end else if (m_ph == 2) begin
        if (frame_done) begin
          if (frame_err) begin m_sav = after(m_idx, m_wrap); m_ph = 4; end
          else m_ph = 3;
        end
      end else if (m_ph == 3) begin
        if (tx_en && !m_last) begin m_idx = after(m_idx, m_wrap); m_ph = 1; end
        else begin m_sav = after(m_idx, m_wrap); m_ph = 5; end
      end else if (m_ph == 4) begin
        if (int'(err_clr_tgl) != m_tg_prev) begin
          if (tx_en) begin m_idx = m_sav; m_ph = 1; end
          else m_ph = 5;
        end
      end
      m_en_prev = int'(tx_en);
      m_tg_prev = int'(err_clr_tgl);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // compare on every falling edge, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check("R1 dma_req_en", int'(dma_req_en), int'(m_ph == 2));
      check("R6 desc_idx", int'(desc_idx), m_idx);
      check("R3 resume_ptr", int'(resume_ptr), m_sav);
      check("R7 stalled", int'(stalled), int'(m_ph == 4 || m_ph == 5));
    end
  end

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wait_req();
    int guard = 0;
    while (!dma_req_en && guard < 50) begin @(negedge clk); guard++; end
  endtask

  // one frame: wait for the gate, send len cycles, pulse done; drop enable at offset if asked
  task automatic frame(input int len, input bit err, input int drop_at);
    wait_req();
    for (int k = 0; k < len; k++) begin
      if (k == drop_at) tx_en = 1'b0;
      @(negedge clk);
    end
    if (drop_at == len) tx_en = 1'b0;
    frame_done = 1'b1; frame_err = err;
    @(negedge clk);
    frame_done = 1'b0; frame_err = 1'b0;
  endtask

  task automatic start_at(input int p);
    start_ptr = 8'(p);
    tx_en = 1'b0; @(negedge clk);
    tx_en = 1'b1;
  endtask

  initial begin
    ticks(3);
    // R10 reset values
    check("R10 dma_req_en", int'(dma_req_en), 0);
    check("R10 stalled", int'(stalled), 0);
    check("R10 desc_idx", int'(desc_idx), 0);
    check("R10 resume_ptr", int'(resume_ptr), 0);
    rst_n = 1'b1;
    ticks(2);

    // R5 start at 0x10 and run three frames, R1 gate timing
    start_at(16);
    ticks(1);
    check("R5 desc_idx after enable rise", int'(desc_idx), 16);
    check("R1 gate not yet open", int'(dma_req_en), 0);
    frame(4, 0, 99);
    frame(2, 0, 99);
    // R2 drop enable mid-frame: frame completes, then stop
    frame(5, 0, 2);
    ticks(3);
    check("R3 resume after disable", int'(resume_ptr), 19);
    check("R7 stalled after disable", int'(stalled), 1);

    // R2 drop enable in the same cycle as frame_done
    start_at(30);
    frame(3, 0, 3);
    ticks(3);
    check("R3 resume after coincident disable", int'(resume_ptr), 31);

    // R6 wrap flag and 255 -> 0
    wrap_at = 41;
    start_at(40);
    frame(1, 0, 99); frame(1, 0, 99); frame(1, 0, 99);
    ticks(1);
    tx_en = 1'b0;
    frame(1, 0, 99);
    ticks(3);
    wrap_at = 999;
    start_at(254);
    frame(1, 0, 99); frame(1, 0, 99);
    ticks(1);
    check("R6 index after 255", int'(desc_idx), 0);
    frame(1, 0, 0);
    ticks(3);

    // R8 toggle while stopped has no effect
    err_clr_tgl = ~err_clr_tgl;
    ticks(3);
    check("R8 still stalled after stray toggle", int'(stalled), 1);

    // R4 error hold, toggle with enable high resumes at saved index
    start_at(100);
    frame(2, 1, 99);
    ticks(4);
    check("R4 hold keeps stalled", int'(stalled), 1);
    check("R3 resume after error", int'(resume_ptr), 101);
    err_clr_tgl = ~err_clr_tgl;
    ticks(2);
    check("R4 resumed at saved index", int'(desc_idx), 101);
    // R4 error hold, disable first then toggle (falling direction, R8)
    frame(2, 1, 99);
    ticks(2);
    tx_en = 1'b0;
    ticks(4);
    check("R4 disable deferred in hold", int'(stalled), 1);
    err_clr_tgl = ~err_clr_tgl;
    ticks(3);
    check("R4 stopped after toggle", int'(stalled), 1);
    check("R1 no request after toggle with disable", int'(dma_req_en), 0);

    // R9 end-of-chain flag stops with enable high
    last_at = 201;
    start_at(200);
    frame(2, 0, 99); frame(2, 0, 99);
    ticks(3);
    check("R9 stopped at chain end", int'(stalled), 1);
    check("R9 resume after chain end", int'(resume_ptr), 202);
    ticks(5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    ticks(20000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule